// File: doc/BRIEF.md
# Link Test Pattern Generator and Checker

This block stands at both ends of a point-to-point data link when the link is run on synthetic traffic instead of live samples. Its generator side emits one test word per step, either a free-running 16-bit count or a sine-like waveform from a numerically controlled oscillator (NCO). Its checker side watches the words arriving from a link. It forms its own prediction of each word, acquires lock on the incoming pattern, and tallies every mismatch found while locked. One tally counts wrong words and the other counts wrong bits.

Placing a checker before and after every hop lets a failing connection be located by comparing tallies. The tallies saturate rather than wrap, so they stay meaningful over very long runs at very low error rates. They can be read after a short test or after a whole acquisition. A small four-address register port sets the pattern and the oscillator step, restarts the pattern, clears the tallies, and returns the tallies. It also returns the lock state and two sticky flags, one for lost lock and one for a saturated tally.

Top module: `lpat_top`

## Requirements
- R1: After reset both tallies are zero, the control read value is zero, the checker is unlocked and the generator word is zero.
- R2: In count mode (control bit 0 = 0) each generator step adds one to the generator word modulo 2^16, and a restart (control write with bit 2 set) returns it to zero.
- R3: In NCO mode (control bit 0 = 1) each step adds the 24-bit increment (address 1) to a phase that restarts at zero. The word is a folded table value indexed by phase bits 23:16. With quadrant q = index[7:6], a = index[5:0] and r = a for even q or 64-a for odd q, the magnitude is floor(32767*r*(128-r)/4096), negated (two's complement) when q is 2 or 3.
- R4: The first word received after a restart seeds the checker and is never compared. In count mode the next word is predicted as that word plus one. In NCO mode that word is taken as phase zero.
- R5: An unlocked checker becomes locked after 8 consecutive correct predictions, shown on link_locked and as control read bit 1.
- R6: A locked checker drops lock on the 4th consecutive mismatch and sets the sticky link-down flag (control read bit 2). Fewer mismatches in a row keep lock. A restart drops lock without setting the flag.
- R7: Words received while unlocked leave both tallies unchanged. In count mode, an unlocked mismatch reseeds the prediction from the received word.
- R8: Each mismatched word received while locked adds one to the word tally (address 2) and adds the population count of received XOR predicted to the bit tally (address 3).
- R9: Both tallies saturate at all ones. Any increment that would pass full scale sets the sticky overflow flag (control read bit 3).
- R10: A control write with bit 1 set zeroes both tallies and both sticky flags without touching lock. The increment written at address 1 reads back unchanged.
- R11: A mismatch while locked in count mode advances the prediction from the checker's own previous prediction, so a single corrupted word yields exactly one word error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_step | input | 1 | Advance the generator by one word |
| gen_word | output | WORD_W | Current generator word |
| rx_valid | input | 1 | A received word is present |
| rx_word | input | WORD_W | Received word to check |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control/status, 1 increment, 2 word tally, 3 bit tally |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr (combinational) |
| link_locked | output | 1 | Checker is locked |

## Verification
The bench builds the block with 8-bit tallies and keeps the default 8-word lock and 4-word loss thresholds and 24-bit phase. The narrow tallies make saturation of both counters and the overflow flag reachable within a few hundred words. The bench then checks that the word tally holds at full scale while errors continue. At default width these cases would need billions of errors. Sine table corners such as the positive and negative peaks are reached directly with an increment of one index per step.

// File: rtl/lpat_pkg.sv
package lpat_pkg;

    typedef enum logic {
        PAT_COUNT = 1'b0,
        PAT_NCO   = 1'b1
    } pat_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_INC  = 2'd1;
    localparam logic [1:0] ADDR_WERR = 2'd2;
    localparam logic [1:0] ADDR_BERR = 2'd3;

    localparam int CTRL_MODE_BIT    = 0;
    localparam int CTRL_CLEAR_BIT   = 1;
    localparam int CTRL_RESTART_BIT = 2;

endpackage

// File: rtl/lpat_sine.sv
module lpat_sine #(
    parameter int OUT_W = 16,
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] sample
);
    localparam int    QN  = 2 ** (IDX_W - 2);
    localparam longint AMP = (longint'(1) << (OUT_W - 1)) - 1;

    // Quarter-wave magnitudes, parabolic sine approximation, entries 0..QN
    logic [OUT_W-1:0] qtab [0:QN];

    for (genvar k = 0; k <= QN; k++) begin : g_qtab
        localparam longint QV = (AMP * k * (2 * QN - k)) / (longint'(QN) * QN);
        assign qtab[k] = QV[OUT_W-1:0];
    end

    logic [1:0]       quad;
    logic [IDX_W-2:0] ridx;
    logic [OUT_W-1:0] mag;

    always_comb begin
        quad   = idx[IDX_W-1 -: 2];
        ridx   = quad[0] ? ((IDX_W-1)'(QN) - {1'b0, idx[IDX_W-3:0]})
                         : {1'b0, idx[IDX_W-3:0]};
        mag    = qtab[ridx];
        sample = quad[1] ? (~mag + OUT_W'(1)) : mag;
    end

endmodule

// File: rtl/lpat_gen.sv
module lpat_gen
    import lpat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PH_W   = 24,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  pat_mode_e         mode,
    input  logic [PH_W-1:0]   phase_inc,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [PH_W-1:0]   phase;
    } gen_s;

    gen_s gen_d, gen_q;
    logic [WORD_W-1:0] nco_word;

    lpat_sine #(.OUT_W(WORD_W), .IDX_W(IDX_W)) u_sine (
        .idx    (gen_q.phase[PH_W-1 -: IDX_W]),
        .sample (nco_word)
    );

    always_comb begin
        gen_d = gen_q;
        if (restart) begin
            gen_d = '0;
        end else if (step) begin
            gen_d.cnt   = gen_q.cnt + WORD_W'(1);
            gen_d.phase = gen_q.phase + phase_inc;
        end
        word = (mode == PAT_NCO) ? nco_word : gen_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    // R2: counting step moves the word up by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && mode == PAT_COUNT) |=>
            (mode != PAT_COUNT) || (word == WORD_W'($past(word) + WORD_W'(1))));

    // R2/R3: both patterns start from a zero word after restart
    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (word == '0));

endmodule

// File: rtl/lpat_chk.sv
module lpat_chk
    import lpat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PH_W   = 24,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 32,
    parameter int LOCK_N = 8,
    parameter int LOSS_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pat_mode_e         mode,
    input  logic [PH_W-1:0]   phase_inc,
    input  logic              restart,
    input  logic              clear,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              locked,
    output logic              link_down,
    output logic              ovf,
    output logic [CNT_W-1:0]  word_errs,
    output logic [CNT_W-1:0]  bit_errs
);
    localparam int GR_W = $clog2(LOCK_N + 1);
    localparam int BR_W = $clog2(LOSS_N + 1);
    localparam int PC_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              seeded;
        logic              locked;
        logic [GR_W-1:0]   good_run;
        logic [BR_W-1:0]   bad_run;
        logic [WORD_W-1:0] pred_cnt;
        logic [PH_W-1:0]   phase;
        logic [CNT_W-1:0]  werr;
        logic [CNT_W-1:0]  berr;
        logic              link_down;
        logic              ovf;
    } chk_s;

    chk_s chk_d, chk_q;
    logic [WORD_W-1:0] nco_pred;

    lpat_sine #(.OUT_W(WORD_W), .IDX_W(IDX_W)) u_sine (
        .idx    (chk_q.phase[PH_W-1 -: IDX_W]),
        .sample (nco_pred)
    );

    always_comb begin
        logic [WORD_W-1:0] pred;
        logic [WORD_W-1:0] diff;
        logic [PC_W-1:0]   nbits;
        logic [CNT_W:0]    bsum;
        logic              err;
        logic              lose;

        chk_d = chk_q;
        pred  = (mode == PAT_NCO) ? nco_pred : chk_q.pred_cnt;
        diff  = rx_data ^ pred;
        err   = |diff;
        nbits = '0;
        for (int i = 0; i < WORD_W; i++) nbits = nbits + PC_W'(diff[i]);
        bsum  = {1'b0, chk_q.berr} + (CNT_W+1)'(nbits);
        lose  = 1'b0;

        if (restart) begin
            chk_d.seeded   = 1'b0;
            chk_d.locked   = 1'b0;
            chk_d.good_run = '0;
            chk_d.bad_run  = '0;
            chk_d.pred_cnt = '0;
            chk_d.phase    = '0;
        end else if (rx_valid) begin
            if (!chk_q.seeded) begin
                chk_d.seeded   = 1'b1;
                chk_d.pred_cnt = rx_data + WORD_W'(1);
                chk_d.phase    = phase_inc;
            end else begin
                chk_d.phase = chk_q.phase + phase_inc;
                if (chk_q.locked) begin
                    if (err) begin
                        if (chk_q.werr == CNT_MAX) chk_d.ovf = 1'b1;
                        else chk_d.werr = chk_q.werr + CNT_W'(1);
                        if (bsum[CNT_W]) begin
                            chk_d.berr = CNT_MAX;
                            chk_d.ovf  = 1'b1;
                        end else begin
                            chk_d.berr = bsum[CNT_W-1:0];
                        end
                        if (chk_q.bad_run == BR_W'(LOSS_N - 1)) begin
                            lose              = 1'b1;
                            chk_d.locked      = 1'b0;
                            chk_d.bad_run     = '0;
                            chk_d.good_run    = '0;
                            chk_d.link_down   = 1'b1;
                        end else begin
                            chk_d.bad_run = chk_q.bad_run + BR_W'(1);
                        end
                    end else begin
                        chk_d.bad_run = '0;
                    end
                end else begin
                    if (err) begin
                        chk_d.good_run = '0;
                    end else if (chk_q.good_run == GR_W'(LOCK_N - 1)) begin
                        chk_d.locked   = 1'b1;
                        chk_d.good_run = '0;
                    end else begin
                        chk_d.good_run = chk_q.good_run + GR_W'(1);
                    end
                end
                chk_d.pred_cnt = (err && !(chk_q.locked && !lose))
                               ? rx_data + WORD_W'(1)
                               : chk_q.pred_cnt + WORD_W'(1);
            end
        end

        if (clear) begin
            chk_d.werr      = '0;
            chk_d.berr      = '0;
            chk_d.link_down = 1'b0;
            chk_d.ovf       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign locked    = chk_q.locked;
    assign link_down = chk_q.link_down;
    assign ovf       = chk_q.ovf;
    assign word_errs = chk_q.werr;
    assign bit_errs  = chk_q.berr;

    // R7: tallies stay put while unlocked
    assert_unlocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_q.locked && !clear) |=> ($stable(chk_q.werr) && $stable(chk_q.berr)));

    // R8: every counted word carries at least one wrong bit
    assert_bits_cover_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q.berr >= chk_q.werr);

    // R5: lock is only gained on a received word
    assert_lock_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_q.locked) |-> $past(rx_valid));

    // R6: losing lock through mismatches raises the sticky flag
    assert_loss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(chk_q.locked) && !$past(restart) && !$past(clear)) |-> chk_q.link_down);

    // R9: a full tally holds until cleared
    assert_word_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.werr == CNT_MAX && !clear) |=> (chk_q.werr == CNT_MAX));

    // R9: overflow flag is sticky
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.ovf && !clear) |=> chk_q.ovf);

endmodule

// File: rtl/lpat_top.sv
module lpat_top
    import lpat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PH_W   = 24,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 32,
    parameter int LOCK_N = 8,
    parameter int LOSS_N = 4,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_step,
    output logic [WORD_W-1:0] gen_word,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              link_locked
);
    typedef struct packed {
        pat_mode_e       mode;
        logic [PH_W-1:0] inc;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic restart, clear;
    logic link_down, ovf;
    logic [CNT_W-1:0] word_errs, bit_errs;
    logic wdata_unused;

    always_comb begin
        cfg_d   = cfg_q;
        restart = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_RESTART_BIT];
        clear   = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_CLEAR_BIT];
        if (reg_wr && reg_addr == ADDR_CTRL) cfg_d.mode = pat_mode_e'(reg_wdata[CTRL_MODE_BIT]);
        if (reg_wr && reg_addr == ADDR_INC)  cfg_d.inc  = reg_wdata[PH_W-1:0];
        case (reg_addr)
            ADDR_CTRL: reg_rdata = REG_W'({ovf, link_down, link_locked, cfg_q.mode});
            ADDR_INC:  reg_rdata = REG_W'(cfg_q.inc);
            ADDR_WERR: reg_rdata = REG_W'(word_errs);
            default:   reg_rdata = REG_W'(bit_errs);
        endcase
    end

    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: PAT_COUNT, inc: '0};
        else        cfg_q <= cfg_d;
    end

    lpat_gen #(.WORD_W(WORD_W), .PH_W(PH_W), .IDX_W(IDX_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (gen_step),
        .restart   (restart),
        .mode      (cfg_q.mode),
        .phase_inc (cfg_q.inc),
        .word      (gen_word)
    );

    lpat_chk #(
        .WORD_W(WORD_W), .PH_W(PH_W), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)
    ) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_q.mode),
        .phase_inc (cfg_q.inc),
        .restart   (restart),
        .clear     (clear),
        .rx_valid  (rx_valid),
        .rx_data   (rx_word),
        .locked    (link_locked),
        .link_down (link_down),
        .ovf       (ovf),
        .word_errs (word_errs),
        .bit_errs  (bit_errs)
    );

    // R10: increment register takes the written value
    assert_inc_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_INC) |=> (cfg_q.inc == $past(reg_wdata[PH_W-1:0])));

    // R10: clear empties both tallies on the next cycle
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_errs == '0 && bit_errs == '0 && !ovf && !link_down));

endmodule

// File: tb/tb_lpat_top.sv
module tb_lpat_top;
    localparam int CNT_W = 8;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_step = 1'b0;
    logic [15:0] gen_word;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_locked;

    int n_cmp = 0;
    int n_bad = 0;

    // expected tally model
    int   ew = 0, eb = 0;
    logic eovf = 1'b0;
    logic [15:0] exp_next;

    always #10 clk = ~clk;

    lpat_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .gen_step(gen_step), .gen_word(gen_word),
        .rx_valid(rx_valid), .rx_word(rx_word), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_locked(link_locked)
    );

    function automatic logic [15:0] sine_ref(input int idx);
        int q, a, r, mag;
        q = (idx >> 6) & 3;
        a = idx & 63;
        r = (q % 2 == 1) ? 64 - a : a;
        mag = (32767 * r * (128 - r)) / 4096;
        return (q >= 2) ? 16'(-mag) : 16'(mag);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [15:0] w);
        rx_valid = 1'b1; rx_word = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic step_gen();
        gen_step = 1'b1;
        @(negedge clk);
        gen_step = 1'b0;
    endtask

    task automatic model_err(input logic [15:0] mask);
        if (ew == MAXC) eovf = 1'b1; else ew++;
        if (eb + $countones(mask) > MAXC) begin eb = MAXC; eovf = 1'b1; end
        else eb = eb + $countones(mask);
    endtask

    task automatic model_clear();
        ew = 0; eb = 0; eovf = 1'b0;
    endtask

    task automatic check_tallies(input string tag);
        logic [31:0] v;
        rd(2'd2, v); check({tag, " word tally"}, v, 32'(ew));
        rd(2'd3, v); check({tag, " bit tally"},  v, 32'(eb));
        rd(2'd0, v); check({tag, " overflow flag"}, 32'(v[3]), 32'(eovf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R1 watchdog expired actual=running expected=done");
        n_cmp++; n_bad++;
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] g, mask;
        logic [23:0] ph, inc;
        int exp_cnt, run;
        void'($urandom(32'h5EED_0A11));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 control", v, 0);
        rd(2'd2, v); check("R1 word tally", v, 0);
        rd(2'd3, v); check("R1 bit tally", v, 0);
        check("R1 gen word", 32'(gen_word), 0);
        check("R1 locked", 32'(link_locked), 0);

        // R2: count generator with random stepping
        wr(2'd0, 32'h4);
        exp_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 2 == 1) begin step_gen(); exp_cnt++; end
            else @(negedge clk);
            check("R2 count word", 32'(gen_word), 32'(16'(exp_cnt)));
        end
        wr(2'd0, 32'h4);
        check("R2 restart to zero", 32'(gen_word), 0);

        // R3: NCO generator with random increment
        inc = 24'($urandom) | 24'h1;
        wr(2'd1, 32'(inc));
        rd(2'd1, v); check("R10 increment readback", v, 32'(inc));
        wr(2'd0, 32'h5);
        ph = '0;
        for (int i = 0; i < 40; i++) begin
            check("R3 nco word", 32'(gen_word), 32'(sine_ref(int'(ph[23:16]))));
            step_gen();
            ph = ph + inc;
        end
        // R3 directed: one table index per step, peaks
        wr(2'd1, 32'h0001_0000);
        wr(2'd0, 32'h5);
        for (int i = 0; i < 64; i++) step_gen();
        check("R3 positive peak", 32'(gen_word), 32'h7FFF);
        for (int i = 0; i < 128; i++) step_gen();
        check("R3 negative peak", 32'(gen_word), 32'h8001);
        step_gen();
        check("R3 index 193", 32'(gen_word), 32'(sine_ref(193)));

        // R4/R5/R7: count checker seeding and lock
        wr(2'd0, 32'h6);
        model_clear();
        g = 16'($urandom);
        send(g);                       // seed, not compared
        for (int i = 1; i <= 3; i++) send(g + 16'(i));
        send((g + 16'd4) ^ 16'h8000);  // unlocked mismatch: reseed
        check_tallies("R7 unlocked mismatch");
        g = (g + 16'd4) ^ 16'h8000;
        for (int i = 1; i <= 7; i++) send(g + 16'(i));
        check("R5 not yet locked after 7", 32'(link_locked), 0);
        send(g + 16'd8);
        check("R5 locked after 8", 32'(link_locked), 1);
        rd(2'd0, v); check("R5 lock status bit", 32'(v[1]), 1);
        exp_next = g + 16'd9;

        // R8/R11: single corrupted word
        mask = 16'($urandom) | 16'h0100;
        send(exp_next ^ mask); model_err(mask); exp_next++;
        send(exp_next); exp_next++;
        send(exp_next); exp_next++;
        check_tallies("R8 single error");
        check("R11 still locked", 32'(link_locked), 1);

        // R8/R9: random traffic, bursts up to 3
        run = 0;
        for (int i = 0; i < 200; i++) begin
            if (($urandom % 5 == 0) && run < 3) begin
                mask = 16'($urandom); if (mask == 0) mask = 16'h1;
                send(exp_next ^ mask); model_err(mask); run++;
            end else begin
                send(exp_next); run = 0;
            end
            exp_next++;
        end
        check_tallies("R8 random traffic");
        check("R6 3-burst keeps lock", 32'(link_locked), 1);

        // R10: clear
        wr(2'd0, 32'h2);
        model_clear();
        check_tallies("R10 clear");
        check("R10 clear keeps lock", 32'(link_locked), 1);

        // R6: 3 bad + good keeps lock, then 4 bad drops it
        for (int i = 0; i < 3; i++) begin
            send(exp_next ^ 16'h0003); model_err(16'h0003); exp_next++;
        end
        send(exp_next); exp_next++;
        check("R6 three misses keep lock", 32'(link_locked), 1);
        for (int i = 0; i < 4; i++) begin
            g = exp_next ^ 16'h0001;
            send(g); model_err(16'h0001); exp_next++;
        end
        check("R6 lock lost", 32'(link_locked), 0);
        rd(2'd0, v); check("R6 link-down flag", 32'(v[2]), 1);
        check_tallies("R6 loss counted");
        // R7: garbage while unlocked is not counted
        for (int i = 0; i < 5; i++) begin
            g = 16'($urandom);
            send(g);
        end
        check_tallies("R7 unlocked garbage");
        exp_next = g + 16'd1;
        for (int i = 0; i < 8; i++) begin send(exp_next); exp_next++; end
        check("R7 relocked after reseed", 32'(link_locked), 1);

        // R9: saturation of both tallies
        wr(2'd0, 32'h2);
        model_clear();
        for (int i = 0; i < 300; i++) begin
            send(exp_next ^ 16'h0001); model_err(16'h0001); exp_next++;
            send(exp_next); exp_next++;
        end
        check_tallies("R9 saturation");
        rd(2'd2, v); check("R9 word tally full", v, 32'(MAXC));

        // R4/R8: NCO checker
        inc = 24'($urandom) | 24'h1;
        wr(2'd1, 32'(inc));
        wr(2'd0, 32'h7);
        model_clear();
        ph = '0;
        for (int k = 0; k < 9; k++) begin
            send(sine_ref(int'(ph[23:16]))); ph = ph + inc;
        end
        check("R5 nco locked", 32'(link_locked), 1);
        mask = 16'h0F0F;
        send(sine_ref(int'(ph[23:16])) ^ mask); model_err(mask); ph = ph + inc;
        for (int k = 0; k < 6; k++) begin
            send(sine_ref(int'(ph[23:16]))); ph = ph + inc;
        end
        check_tallies("R8 nco error");
        check("R4 nco stays locked", 32'(link_locked), 1);

        // R6: restart drops lock without flag
        wr(2'd0, 32'h5);
        check("R6 restart unlocks", 32'(link_locked), 0);
        rd(2'd0, v); check("R6 restart no flag", 32'(v[2]), 0);

        summary();
        $finish;
    end

endmodule